// File: doc/BRIEF.md
# Velocity-to-Step Pulse Generator

This block is a single axis of the pulse output stage of a motion controller. A host writes a signed velocity word into a staging register; an on-board update strobe, produced by a periodic timer, copies it into the active register, so the moment a new velocity applies is set by the hardware timer and not by when software wrote it. Every clock the active velocity, sign-extended, is added into a wide phase accumulator that wraps silently.

A range selector picks one high accumulator bit as the step tap. Each change of that bit, in either direction, is one motor step. Choosing a higher tap divides the full-scale step rate by a power of two. The output stage turns each tap change into a step pulse of programmable width and drives a direction line from the sign of the active velocity. The direction line is guaranteed to settle before any step pulse that follows a reversal.

The block is used by writing a velocity into the staging register at any time, strobing the update input once per servo period, and routing the step and direction outputs to a stepper or servo drive.

Top module: `step_rate_gen`

## Requirements
- R1: A write (`cmdWr` high at a clock edge) stores `cmdData` in the staging register only. Until an update strobe follows, the write has no effect on `stepOut` or `dirOut`.
- R2: An update strobe (`updateStb` high at a clock edge) copies the staging register into the active register. If a write and an update strobe happen at the same edge, the value staged before that edge becomes active.
- R3: At every clock edge the 26-bit accumulator adds the active velocity. The velocity is taken as two's complement and sign-extended. The sum wraps modulo 2^26.
- R4: `rangeSel` values 0 to 5 select accumulator bit 20 + `rangeSel` as the step tap. Values 6 and 7 select bit 25.
- R5: Each change of the selected tap bit, rising or falling, yields exactly one step pulse. This holds when tap changes are spaced further apart than the pulse width plus the direction setup time.
- R6: `dirOut` equals the sign bit of the active velocity, where 1 means negative. It follows the update strobe by two clock edges.
- R7: A step pulse stays high for `pulseWidth` clocks, with the value sampled at the edge where the pulse rises. A `pulseWidth` of 0 gives a one-clock pulse.
- R8: `stepOut` never rises earlier than the third clock edge after the edge that changed `dirOut`. A step that is pending during this time is delayed, not dropped.
- R9: Reset (`rstN` low) clears the staging register, the active register and the accumulator, and drives `stepOut` and `dirOut` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cmdWr | input | 1 | Write enable for the staging register |
| cmdData | input | 16 | Signed velocity word |
| updateStb | input | 1 | Periodic update strobe from the servo timer |
| rangeSel | input | 3 | Step tap select |
| pulseWidth | input | 8 | Step pulse high time in clocks |
| stepOut | output | 1 | Step pulse |
| dirOut | output | 1 | Direction, 1 = negative |

## Verification
The bench keeps an arithmetic model of the accumulator and predicts the step count of each window as the number of multiples of 2^tap crossed between the start and end accumulator values. A design with a wrong tap index, a missing sign extension, or a 6/7 range code that is not clamped to tap 25 gives a different count. A write without an update is checked for zero steps and a steady direction line, and a design that bypasses the staging register fails that check. Fast reversals near a tap boundary expose a missing or short direction setup delay. The pulse widths are measured for 0, 1 and 255, which catches an off-by-one in the width counter or a zero width that never ends.

// File: rtl/srg_pkg.sv
`timescale 1ns/1ps
package srg_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic loadShadow;
    logic loadActive;
  } dpStrobe_t;
endpackage

// File: rtl/srg_datapath.sv
`timescale 1ns/1ps
module srg_datapath
  import srg_pkg::*;
#(
  parameter int CMD_W    = 16,
  parameter int ACC_W    = 26,
  parameter int TAP_LO   = 20,
  parameter int NUM_TAPS = 6,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CMD_W-1:0] cmdData,
  input  logic [SEL_W-1:0] rangeSel,
  output logic             tapBit,
  output logic             dirBit
);
  localparam int EXT_W = ACC_W - CMD_W;
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_TAPS - 1);

  logic [CMD_W-1:0]    shadowCmd;
  logic [CMD_W-1:0]    activeCmd;
  logic [ACC_W-1:0]    phaseAcc;
  logic [ACC_W-1:0]    addend;
  logic [NUM_TAPS-1:0] tapVec;
  logic [SEL_W-1:0]    selEff;

  // Staging and active command registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCmd <= '0;
      activeCmd <= '0;
    end else begin
      if (strobe.loadShadow) shadowCmd <= cmdData;
      if (strobe.loadActive) activeCmd <= shadowCmd;
    end
  end

  // Sign extension and phase accumulation, wrapping at ACC_W bits.
  assign addend = {{EXT_W{activeCmd[CMD_W-1]}}, activeCmd};

  always_ff @(posedge clk) begin
    if (!rstN) phaseAcc <= '0;
    else       phaseAcc <= phaseAcc + addend;
  end

  // Candidate taps.
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tapVec[i] = phaseAcc[TAP_LO + i];
  end

  // Codes past the last tap fall back to the highest one.
  always_comb begin
    selEff = (rangeSel > LAST_SEL) ? LAST_SEL : rangeSel;
    tapBit = tapVec[selEff];
    dirBit = activeCmd[CMD_W-1];
  end
endmodule

// File: rtl/srg_control.sv
`timescale 1ns/1ps
module srg_control
  import srg_pkg::*;
#(
  parameter int PW_W    = 8,
  parameter int SETUP   = 2,
  parameter int SETUP_W = $clog2(SETUP + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdWr,
  input  logic            updateStb,
  input  logic            tapBit,
  input  logic            dirBit,
  input  logic [PW_W-1:0] pulseWidth,
  output dpStrobe_t       strobe,
  output logic            stepOut,
  output logic            dirOut
);
  localparam logic [SETUP_W-1:0] SETUP_LD = SETUP_W'(SETUP);

  logic               tapPrev;
  logic               pending;
  logic [SETUP_W-1:0] setupCnt;
  logic [PW_W-1:0]    widthCnt;
  logic               toggle;
  logic               dirChg;
  logic               fire;
  logic [PW_W-1:0]    widthLoad;

  always_comb begin
    strobe.loadShadow = cmdWr;
    strobe.loadActive = updateStb;
    toggle    = tapBit ^ tapPrev;
    dirChg    = dirBit != dirOut;
    fire      = pending && !stepOut && (setupCnt == '0) && !dirChg;
    widthLoad = (pulseWidth == '0) ? PW_W'(1) : pulseWidth;
  end

  // Tap edge detection and the single pending-step slot.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tapPrev <= 1'b0;
      pending <= 1'b0;
    end else begin
      tapPrev <= tapBit;
      pending <= toggle | (pending & ~fire);
    end
  end

  // Direction register with its setup hold-off.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirOut   <= 1'b0;
      setupCnt <= '0;
    end else if (dirChg) begin
      dirOut   <= dirBit;
      setupCnt <= SETUP_LD;
    end else if (setupCnt != '0) begin
      setupCnt <= setupCnt - 1'b1;
    end
  end

  // Step pulse timer.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepOut  <= 1'b0;
      widthCnt <= '0;
    end else if (fire) begin
      stepOut  <= 1'b1;
      widthCnt <= widthLoad;
    end else if (stepOut) begin
      if (widthCnt <= PW_W'(1)) stepOut <= 1'b0;
      else                      widthCnt <= widthCnt - 1'b1;
    end
  end
endmodule

// File: rtl/step_rate_gen.sv
`timescale 1ns/1ps
module step_rate_gen
  import srg_pkg::*;
#(
  parameter int CMD_W    = 16,
  parameter int ACC_W    = 26,
  parameter int TAP_LO   = 20,
  parameter int NUM_TAPS = 6,
  parameter int SEL_W    = 3,
  parameter int PW_W     = 8,
  parameter int SETUP    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic [CMD_W-1:0] cmdData,
  input  logic             updateStb,
  input  logic [SEL_W-1:0] rangeSel,
  input  logic [PW_W-1:0]  pulseWidth,
  output logic             stepOut,
  output logic             dirOut
);
  dpStrobe_t strobe;
  logic      tapBit;
  logic      dirBit;

  srg_datapath #(
    .CMD_W(CMD_W), .ACC_W(ACC_W), .TAP_LO(TAP_LO),
    .NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdData(cmdData),
    .rangeSel(rangeSel), .tapBit(tapBit), .dirBit(dirBit)
  );

  srg_control #(.PW_W(PW_W), .SETUP(SETUP)) u_ctl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .updateStb(updateStb),
    .tapBit(tapBit), .dirBit(dirBit), .pulseWidth(pulseWidth),
    .strobe(strobe), .stepOut(stepOut), .dirOut(dirOut)
  );
endmodule

// File: rtl/step_rate_gen_chk.sv
`timescale 1ns/1ps
module step_rate_gen_chk #(
  parameter int PW_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            updateStb,
  input logic [PW_W-1:0] pulseWidth,
  input logic            stepOut,
  input logic            dirOut
);
  logic [PW_W:0]   hiCnt;
  logic [PW_W-1:0] wLat;

  // Length of the current high phase and the width it should last.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiCnt <= '0;
      wLat  <= PW_W'(1);
    end else begin
      hiCnt <= stepOut ? hiCnt + 1'b1 : '0;
      if (!stepOut) wLat <= (pulseWidth == '0) ? PW_W'(1) : pulseWidth;
    end
  end

  p_width_max_r7: assert property (@(posedge clk) disable iff (!rstN)
    stepOut |-> (hiCnt < {1'b0, wLat}));

  p_width_exact_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stepOut) |-> (hiCnt == {1'b0, wLat}));

  p_dir_setup_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stepOut) |-> (dirOut == $past(dirOut, 1)) && (dirOut == $past(dirOut, 2)));

  p_dir_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dirOut) |-> $past(updateStb, 2));
endmodule

bind step_rate_gen step_rate_gen_chk #(.PW_W(PW_W)) u_chk (
  .clk(clk), .rstN(rstN), .updateStb(updateStb), .pulseWidth(pulseWidth),
  .stepOut(stepOut), .dirOut(dirOut)
);

// File: tb/step_rate_gen_test.sv
`timescale 1ns/1ps
module step_rate_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWr = 1'b0;
  logic [15:0] cmdData = '0;
  logic        updateStb = 1'b0;
  logic [2:0]  rangeSel = '0;
  logic [7:0]  pulseWidth = 8'd1;
  logic        stepOut;
  logic        dirOut;

  always #2.5 clk = ~clk;

  step_rate_gen uut (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData),
    .updateStb(updateStb), .rangeSel(rangeSel), .pulseWidth(pulseWidth),
    .stepOut(stepOut), .dirOut(dirOut)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Arithmetic model of the staged command and the unbounded accumulator.
  longint             mAcc = 0;
  logic signed [15:0] mShadow = '0;
  logic signed [15:0] mActive = '0;
  always @(posedge clk) begin
    if (!rstN) begin
      mAcc = 0; mShadow = '0; mActive = '0;
    end else begin
      mAcc = mAcc + longint'(mActive);
      if (updateStb) mActive = mShadow;
      if (cmdWr) mShadow = cmdData;
    end
  end

  // Output monitor.
  int   rises = 0, hiLen = 0, minW = 1000000, maxW = 0, dirAge = 0, setupViol = 0;
  logic prevStep = 1'b0, prevDir = 1'b0;
  always @(posedge clk) begin
    if (dirOut != prevDir) dirAge = 0;
    else if (dirAge < 100000) dirAge++;
    if (stepOut && !prevStep) begin
      rises++;
      if (dirAge < 3) setupViol++;
    end
    if (stepOut) hiLen++;
    else if (prevStep) begin
      if (hiLen < minW) minW = hiLen;
      if (hiLen > maxW) maxW = hiLen;
      hiLen = 0;
    end
    prevStep = stepOut;
    prevDir  = dirOut;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearStats();
    rises = 0; minW = 1000000; maxW = 0; setupViol = 0;
  endtask

  task automatic writeCmd(input logic [15:0] v);
    cmdWr = 1'b1; cmdData = v; tick(1); cmdWr = 1'b0;
  endtask

  task automatic strobe();
    updateStb = 1'b1; tick(1); updateStb = 1'b0;
  endtask

  // One constant-velocity window: predicted steps = multiples of 2^tap crossed.
  task automatic window(input logic [15:0] v, input logic [2:0] sel,
                        input logic [7:0] w, input int cycles, input string req);
    longint startAcc, endAcc, expSteps;
    int k, expW;
    rangeSel = sel; pulseWidth = w;
    tick(700);
    clearStats();
    startAcc = mAcc;
    writeCmd(v); strobe();
    tick(cycles);
    writeCmd(16'd0); strobe();
    tick(700);
    endAcc = mAcc;
    k = 20 + ((sel > 3'd5) ? 5 : int'(sel));
    expSteps = (endAcc >>> k) - (startAcc >>> k);
    if (expSteps < 0) expSteps = -expSteps;
    check(rises == expSteps, req, "step count", rises, expSteps);
    expW = (w == 8'd0) ? 1 : int'(w);
    if (rises > 0) begin
      check(minW == expW && maxW == expW, "R7", "pulse width", maxW, expW);
    end
  endtask

  initial begin
    // R9: reset state
    tick(4);
    check(stepOut == 1'b0, "R9", "stepOut in reset", stepOut, 0);
    check(dirOut == 1'b0, "R9", "dirOut in reset", dirOut, 0);
    rstN = 1'b1;
    tick(2);

    // R1: staged writes alone change nothing at the outputs
    rangeSel = 3'd0; pulseWidth = 8'd2;
    clearStats();
    writeCmd(16'sd20000);
    tick(3000);
    check(rises == 0, "R1", "steps without update", rises, 0);
    writeCmd(16'hFFFB);
    tick(100);
    check(dirOut == 1'b0, "R1", "dir without update", dirOut, 0);

    // R6 / R2: direction follows the active sign two edges after the strobe
    updateStb = 1'b1; tick(1); updateStb = 1'b0;
    check(dirOut == 1'b0, "R6", "dir one edge after strobe", dirOut, 0);
    tick(1);
    check(dirOut == 1'b1, "R6", "dir two edges after strobe", dirOut, 1);

    // R2: write and strobe together activate the previously staged value
    cmdWr = 1'b1; cmdData = 16'd100; updateStb = 1'b1;
    tick(1);
    cmdWr = 1'b0; updateStb = 1'b0;
    tick(3);
    check(dirOut == 1'b1, "R2", "old staged value active", dirOut, 1);
    strobe();
    tick(3);
    check(dirOut == 1'b0, "R2", "new staged value active", dirOut, 0);
    writeCmd(16'd0); strobe();

    // R3 / R4 / R5 / R7: sweep of taps, signs and widths
    window(16'sd32767,  3'd0, 8'd4,   3000, "R5");
    window(-16'sd32767, 3'd0, 8'd4,   3000, "R3");
    window(16'sd20000,  3'd1, 8'd3,   3000, "R4");
    window(-16'sd12345, 3'd2, 8'd2,   4000, "R3");
    window(16'sd32767,  3'd3, 8'd1,   3000, "R4");
    window(-16'sd30000, 3'd4, 8'd6,   5000, "R4");
    window(16'sd32767,  3'd5, 8'd255, 5000, "R7");
    window(-16'sd32767, 3'd6, 8'd0,   5000, "R4");
    window(16'sd32767,  3'd7, 8'd9,   5000, "R4");

    // R8: rapid reversals around a tap boundary
    rangeSel = 3'd0; pulseWidth = 8'd2;
    tick(700);
    clearStats();
    for (int i = 0; i < 60; i++) begin
      writeCmd((i % 2) ? -16'sd32767 : 16'sd32767);
      strobe();
      tick(30 + (i % 7));
    end
    writeCmd(16'd0); strobe();
    tick(700);
    check(setupViol == 0, "R8", "steps inside dir setup", setupViol, 0);
    check(rises > 0, "R8", "steps during reversals", rises, 1);

    // R9: reset mid-run clears active and staged values
    writeCmd(-16'sd32767); strobe();
    tick(200);
    rstN = 1'b0;
    tick(3);
    check(stepOut == 1'b0 && dirOut == 1'b0, "R9", "outputs in mid-run reset",
          {stepOut, dirOut}, 0);
    rstN = 1'b1;
    clearStats();
    strobe();
    tick(3000);
    check(rises == 0, "R9", "steps after reset", rises, 0);
    check(dirOut == 1'b0, "R9", "dir after reset", dirOut, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule